// File: doc/BRIEF.md
# Clock Frequency Source Selector

This block is the control logic that decides which frequency setting a clock synthesizer runs at. The strap pins are captured once, on the first cycle the active-low power-good strobe is seen low, and held from then on. After that, the host registers choose between the strapped 5-bit code and a software code. They also choose whether the CPU divider comes from the frequency table or from a programmable N/M pair, where the output frequency is G·(N+3)/(M+3). The block presents the resulting code, divider pair and current-multiplier selection to the synthesizer.

A watchdog recovery request locks the selector into a recovery setting. That setting is either the strapped code or a dedicated recovery N/M pair. While the lock holds, host changes to the frequency are ignored, and clearing the watchdog enable releases it. Every change of the effective setting gives a one-cycle load pulse to the synthesizer, followed one cycle later by a frequency-change event for the watchdog and the reset generator.

Top module: `clk_freq_select`

## Requirements
- R1: Strap code and multiplier strap are captured at the first rising clock edge where `pwr_good_ni` is 0. `strap_valid_o` is 1 from the next cycle on. Later strap or `pwr_good_ni` activity changes nothing.
- R2: When unlocked, `code_o` equals (`code_ovr_i` ? `sw_code_i` : latched strap code) one cycle after the inputs.
- R3: When unlocked, `use_nm_o` follows `prog_en_i` one cycle later, and `n_o`/`m_o` show the programmable pair.
- R4: A write strobe on `prog_n_wr_i` or `prog_m_wr_i` with N > M stores the pair from `prog_n_i`/`prog_m_i`, which is visible the next cycle. It gives a load pulse if `prog_en_i` is 1.
- R5: A write whose N is not greater than M is discarded. The previous pair stays and no load pulse is produced (N = M+1 is the smallest accepted N).
- R6: When unlocked, `load_o` pulses for one cycle whenever `code_o` or `use_nm_o` changes.
- R7: `rcv_req_i` with `wd_en_i` = 1 sets `rcv_lock_o` the next cycle and gives a load pulse. With `rcv_sel_i` = 0 the code is the strap code and `use_nm_o` = 0. With `rcv_sel_i` = 1, `use_nm_o` = 1, the recovery pair is driven, and the code follows the R2 choice. `rcv_req_i` with `wd_en_i` = 0 is ignored.
- R8: While locked, changes to the host code, override, `prog_en_i` and programmable pair leave `code_o`, `use_nm_o`, `n_o`, `m_o` unchanged. A valid recovery-pair write updates `n_o`/`m_o` with a load pulse when the recovery pair is in use.
- R9: With `wd_en_i` = 0 the lock clears on the next edge. The host setting is restored in the same edge, with a load pulse.
- R10: `mult_o` is `sw_mult_i` when `mult_ovr_i` = 1, else {latched multiplier strap, 0} (00 = 4x, 10 = 6x).
- R11: `freq_chg_o` is high exactly in the cycle after each `load_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_ni | input | 1 | Power-good strobe, active low |
| strap_fs_i | input | 5 | Frequency strap pins |
| strap_mult_i | input | 1 | Current-multiplier strap |
| sw_code_i | input | 5 | Software frequency code |
| code_ovr_i | input | 1 | 1 selects software code |
| prog_en_i | input | 1 | Programmable N/M enable |
| prog_n_i | input | 8 | Programmable N field |
| prog_m_i | input | 7 | Programmable M field |
| prog_n_wr_i | input | 1 | Write strobe of N field |
| prog_m_wr_i | input | 1 | Write strobe of M field |
| rcv_sel_i | input | 1 | Recovery source: 0 strap code, 1 recovery pair |
| rcv_n_i | input | 8 | Recovery N field |
| rcv_m_i | input | 7 | Recovery M field |
| rcv_n_wr_i | input | 1 | Write strobe of recovery N |
| rcv_m_wr_i | input | 1 | Write strobe of recovery M |
| wd_en_i | input | 1 | Watchdog enable; 0 releases lock |
| rcv_req_i | input | 1 | Watchdog recovery request |
| mult_ovr_i | input | 1 | 1 selects software multiplier |
| sw_mult_i | input | 2 | Software multiplier code |
| code_o | output | 5 | Effective frequency code |
| use_nm_o | output | 1 | Divider from N/M pair |
| n_o | output | 8 | Effective N |
| m_o | output | 7 | Effective M |
| mult_o | output | 2 | Effective multiplier code |
| strap_valid_o | output | 1 | Straps captured |
| rcv_lock_o | output | 1 | Recovery lock active |
| load_o | output | 1 | One-cycle synthesizer load pulse |
| freq_chg_o | output | 1 | Frequency-change event |

## Verification
The bench builds the block with its default widths: a 5-bit code, an 8-bit N and a 7-bit M. This makes the ratio boundary N = M and N = M+1 reachable with realistic divider values. The full code space is open to both the strap and software paths, so a strap code and a software code can be told apart in every mode. Both recovery sources are driven through lock entry, hold and release. Host writes are made during the lock so that any leakage appears on the outputs.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  typedef enum logic [1:0] {
    MODE_HOST  = 2'd0,
    MODE_ENTER = 2'd1,
    MODE_HOLD  = 2'd2,
    MODE_EXIT  = 2'd3
  } fsel_mode_e;
endpackage

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch #(
  parameter int CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pg_ni,
  input  logic [CODE_W-1:0] fs_i,
  input  logic              mult_i,
  output logic [CODE_W-1:0] fs_o,
  output logic              mult_o,
  output logic              valid_o
);
  logic [CODE_W-1:0] fs_q;
  logic              mult_q, valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q    <= '0;
      mult_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (!valid_q && !pg_ni) begin
      fs_q    <= fs_i;
      mult_q  <= mult_i;
      valid_q <= 1'b1;
    end
  end

  assign fs_o    = fs_q;
  assign mult_o  = mult_q;
  assign valid_o = valid_q;

  AST_STRAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && $past(valid_q) |-> $stable(fs_q) && $stable(mult_q)); // R1
endmodule

// File: rtl/fsel_pair_reg.sv
module fsel_pair_reg #(
  parameter int N_W = 8,
  parameter int M_W = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_n_i,
  input  logic           wr_m_i,
  input  logic [N_W-1:0] n_i,
  input  logic [M_W-1:0] m_i,
  output logic [N_W-1:0] n_o,
  output logic [M_W-1:0] m_o,
  output logic           acc_o
);
  localparam int CW = N_W + 1;

  logic [N_W-1:0] n_q;
  logic [M_W-1:0] m_q;
  logic [CW-1:0]  n_in_x, m_in_x, n_q_x, m_q_x;

  assign n_in_x = CW'(n_i);
  assign m_in_x = CW'(m_i);
  assign n_q_x  = CW'(n_q);
  assign m_q_x  = CW'(m_q);
  // (N+3) > (M+3) reduces to N > M
  assign acc_o  = (wr_n_i || wr_m_i) && (n_in_x > m_in_x);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q <= '0;
      m_q <= '0;
    end else if (acc_o) begin
      n_q <= n_i;
      m_q <= m_i;
    end
  end

  assign n_o = n_q;
  assign m_o = m_q;

  AST_PAIR_RATIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({n_q, m_q}) |-> n_q_x > m_q_x); // R5
endmodule

// File: rtl/fsel_ctrl.sv
module fsel_ctrl
  import fsel_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] strap_code_i,
  input  logic [CODE_W-1:0] sw_code_i,
  input  logic              code_ovr_i,
  input  logic              prog_en_i,
  input  logic              prog_acc_i,
  input  logic              rcv_acc_i,
  input  logic              rcv_sel_i,
  input  logic              wd_en_i,
  input  logic              rcv_req_i,
  output logic [CODE_W-1:0] code_o,
  output logic              use_nm_o,
  output logic              lock_o,
  output logic              load_o,
  output logic              chg_o
);
  fsel_mode_e        mode;
  logic [CODE_W-1:0] host_code, code_q, code_nx;
  logic              use_q, use_nx, lock_q, lock_nx, load_q, load_nx, chg_q;

  assign host_code = code_ovr_i ? sw_code_i : strap_code_i;

  always_comb begin
    if (!lock_q) mode = (wd_en_i && rcv_req_i) ? MODE_ENTER : MODE_HOST;
    else         mode = wd_en_i ? MODE_HOLD : MODE_EXIT;
  end

  always_comb begin
    code_nx = code_q;
    use_nx  = use_q;
    lock_nx = lock_q;
    load_nx = 1'b0;
    unique case (mode)
      MODE_HOST, MODE_EXIT: begin
        code_nx = host_code;
        use_nx  = prog_en_i;
        lock_nx = 1'b0;
        load_nx = (mode == MODE_EXIT) || (code_nx != code_q) ||
                  (use_nx != use_q) || (prog_en_i && prog_acc_i);
      end
      MODE_ENTER: begin
        code_nx = rcv_sel_i ? host_code : strap_code_i;
        use_nx  = rcv_sel_i;
        lock_nx = 1'b1;
        load_nx = 1'b1;
      end
      default: begin
        load_nx = use_q && rcv_acc_i;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      use_q  <= 1'b0;
      lock_q <= 1'b0;
      load_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      code_q <= code_nx;
      use_q  <= use_nx;
      lock_q <= lock_nx;
      load_q <= load_nx;
      chg_q  <= load_q;
    end
  end

  assign code_o   = code_q;
  assign use_nm_o = use_q;
  assign lock_o   = lock_q;
  assign load_o   = load_q;
  assign chg_o    = chg_q;

  AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q && $past(lock_q) |-> $stable(code_q) && $stable(use_q)); // R8
  AST_WD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_en_i |=> !lock_q); // R9
  AST_ENTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q && wd_en_i && rcv_req_i |=> lock_q && load_q); // R7
endmodule

// File: rtl/clk_freq_select.sv
module clk_freq_select #(
  parameter int CODE_W = 5,
  parameter int N_W    = 8,
  parameter int M_W    = 7,
  parameter int MULT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_ni,
  input  logic [CODE_W-1:0] strap_fs_i,
  input  logic              strap_mult_i,
  input  logic [CODE_W-1:0] sw_code_i,
  input  logic              code_ovr_i,
  input  logic              prog_en_i,
  input  logic [N_W-1:0]    prog_n_i,
  input  logic [M_W-1:0]    prog_m_i,
  input  logic              prog_n_wr_i,
  input  logic              prog_m_wr_i,
  input  logic              rcv_sel_i,
  input  logic [N_W-1:0]    rcv_n_i,
  input  logic [M_W-1:0]    rcv_m_i,
  input  logic              rcv_n_wr_i,
  input  logic              rcv_m_wr_i,
  input  logic              wd_en_i,
  input  logic              rcv_req_i,
  input  logic              mult_ovr_i,
  input  logic [MULT_W-1:0] sw_mult_i,
  output logic [CODE_W-1:0] code_o,
  output logic              use_nm_o,
  output logic [N_W-1:0]    n_o,
  output logic [M_W-1:0]    m_o,
  output logic [MULT_W-1:0] mult_o,
  output logic              strap_valid_o,
  output logic              rcv_lock_o,
  output logic              load_o,
  output logic              freq_chg_o
);
  logic [CODE_W-1:0] strap_code;
  logic              strap_mult;
  logic [N_W-1:0]    p_n, r_n;
  logic [M_W-1:0]    p_m, r_m;
  logic              p_acc, r_acc, lock;

  fsel_strap_latch #(.CODE_W(CODE_W)) u_strap (
    .clk_i, .rst_ni, .pg_ni(pwr_good_ni), .fs_i(strap_fs_i), .mult_i(strap_mult_i),
    .fs_o(strap_code), .mult_o(strap_mult), .valid_o(strap_valid_o)
  );

  fsel_pair_reg #(.N_W(N_W), .M_W(M_W)) u_prog_pair (
    .clk_i, .rst_ni, .wr_n_i(prog_n_wr_i), .wr_m_i(prog_m_wr_i),
    .n_i(prog_n_i), .m_i(prog_m_i), .n_o(p_n), .m_o(p_m), .acc_o(p_acc)
  );

  fsel_pair_reg #(.N_W(N_W), .M_W(M_W)) u_rcv_pair (
    .clk_i, .rst_ni, .wr_n_i(rcv_n_wr_i), .wr_m_i(rcv_m_wr_i),
    .n_i(rcv_n_i), .m_i(rcv_m_i), .n_o(r_n), .m_o(r_m), .acc_o(r_acc)
  );

  fsel_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk_i, .rst_ni, .strap_code_i(strap_code), .sw_code_i, .code_ovr_i,
    .prog_en_i, .prog_acc_i(p_acc), .rcv_acc_i(r_acc), .rcv_sel_i, .wd_en_i,
    .rcv_req_i, .code_o, .use_nm_o, .lock_o(lock), .load_o, .chg_o(freq_chg_o)
  );

  assign rcv_lock_o = lock;
  assign n_o        = lock ? r_n : p_n;
  assign m_o        = lock ? r_m : p_m;
  // strap 0 -> 4x (00), strap 1 -> 6x (10)
  assign mult_o     = mult_ovr_i ? sw_mult_i : {strap_mult, {(MULT_W-1){1'b0}}};
endmodule

// File: tb/clk_freq_select_bench.sv
module clk_freq_select_bench;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic pwr_good_ni = 1'b1, strap_mult_i = 1'b0, code_ovr_i = 1'b0, prog_en_i = 1'b0;
  logic [4:0] strap_fs_i = '0, sw_code_i = '0;
  logic [7:0] prog_n_i = '0, rcv_n_i = '0;
  logic [6:0] prog_m_i = '0, rcv_m_i = '0;
  logic prog_n_wr_i = 0, prog_m_wr_i = 0, rcv_n_wr_i = 0, rcv_m_wr_i = 0;
  logic rcv_sel_i = 0, wd_en_i = 0, rcv_req_i = 0, mult_ovr_i = 0;
  logic [1:0] sw_mult_i = '0;
  logic [4:0] code_o;
  logic use_nm_o, strap_valid_o, rcv_lock_o, load_o, freq_chg_o;
  logic [7:0] n_o;
  logic [6:0] m_o;
  logic [1:0] mult_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  clk_freq_select u_clk_freq_select (.*);

  task automatic step(int k = 1);
    for (int i = 0; i < k; i++) @(negedge clk_i);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1 reset valid", strap_valid_o, 0);
    chk("R2 reset code", code_o, 0);
    chk("R6 reset load", load_o, 0);
    chk("R7 reset lock", rcv_lock_o, 0);
  endtask

  task automatic t_strap();
    strap_fs_i = 5'h13; strap_mult_i = 1; pwr_good_ni = 0;
    step();
    chk("R1 valid", strap_valid_o, 1);
    step();
    chk("R2 strap code", code_o, 5'h13);
    chk("R6 load on code", load_o, 1);
    step();
    chk("R11 chg after load", freq_chg_o, 1);
    chk("R6 load one wide", load_o, 0);
    strap_fs_i = 5'h04; strap_mult_i = 0; pwr_good_ni = 1; step(2);
    pwr_good_ni = 0; step(2);
    chk("R1 straps frozen", code_o, 5'h13);
    chk("R10 strap mult 6x", mult_o, 2);
    mult_ovr_i = 1; sw_mult_i = 2'b01; #1;
    chk("R10 sw mult", mult_o, 1);
  endtask

  task automatic t_host();
    code_ovr_i = 1; sw_code_i = 5'h1A; step();
    chk("R2 sw code", code_o, 5'h1A);
    chk("R6 load sw code", load_o, 1);
    prog_n_i = 100; prog_m_i = 45; prog_n_wr_i = 1; step(); prog_n_wr_i = 0;
    chk("R4 pair stored", n_o, 100);
    chk("R4 no load when disabled", load_o, 0);
    prog_en_i = 1; step();
    chk("R3 use_nm", use_nm_o, 1);
    chk("R6 load on enable", load_o, 1);
    prog_n_i = 200; prog_m_wr_i = 1; step(); prog_m_wr_i = 0;
    chk("R4 n updated", n_o, 200);
    chk("R4 load on write", load_o, 1);
    prog_n_i = 45; prog_m_i = 45; prog_m_wr_i = 1; step(); prog_m_wr_i = 0;
    chk("R5 n=m kept", n_o, 200);
    chk("R5 no load", load_o, 0);
    prog_n_i = 46; prog_n_wr_i = 1; step(); prog_n_wr_i = 0;
    chk("R5 n=m+1 accepted", n_o, 46);
    chk("R4 load boundary", load_o, 1);
  endtask

  task automatic t_lock_pair();
    rcv_n_i = 150; rcv_m_i = 93; rcv_n_wr_i = 1; step(); rcv_n_wr_i = 0;
    chk("R8 rcv write unlocked no load", load_o, 0);
    chk("R3 prog pair shown", n_o, 46);
    rcv_sel_i = 1; wd_en_i = 1; rcv_req_i = 1; step(); rcv_req_i = 0;
    chk("R7 locked", rcv_lock_o, 1);
    chk("R7 rcv n", n_o, 150);
    chk("R7 rcv m", m_o, 93);
    chk("R7 use_nm", use_nm_o, 1);
    chk("R7 code by ovr", code_o, 5'h1A);
    chk("R7 load", load_o, 1);
    prog_en_i = 0; code_ovr_i = 0; step(2);
    chk("R8 code held", code_o, 5'h1A);
    chk("R8 use held", use_nm_o, 1);
    chk("R8 no load", load_o, 0);
    prog_n_i = 220; prog_m_i = 45; prog_n_wr_i = 1; step(); prog_n_wr_i = 0;
    chk("R8 prog ignored", n_o, 150);
    rcv_n_i = 160; rcv_m_wr_i = 1; step(); rcv_m_wr_i = 0;
    chk("R8 rcv update", n_o, 160);
    chk("R8 rcv load", load_o, 1);
    wd_en_i = 0; step();
    chk("R9 released", rcv_lock_o, 0);
    chk("R9 host code", code_o, 5'h13);
    chk("R9 host use", use_nm_o, 0);
    chk("R9 host pair", n_o, 220);
    chk("R9 load", load_o, 1);
  endtask

  task automatic t_lock_strap();
    prog_en_i = 1; code_ovr_i = 1; rcv_sel_i = 0; step(2);
    chk("R2 sw code again", code_o, 5'h1A);
    wd_en_i = 1; rcv_req_i = 1; step(); rcv_req_i = 0;
    chk("R7 strap lock", rcv_lock_o, 1);
    chk("R7 strap code", code_o, 5'h13);
    chk("R7 no nm", use_nm_o, 0);
    wd_en_i = 0; rcv_req_i = 1; step();
    chk("R9 release restores", code_o, 5'h1A);
    step();
    chk("R7 req ignored w/o enable", rcv_lock_o, 0);
    chk("R7 no load", load_o, 0);
    rcv_req_i = 0;
  endtask

  initial begin
    step(2);
    t_reset();
    rst_ni = 1; step();
    t_strap();
    t_host();
    t_lock_pair();
    t_lock_strap();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule